// File: doc/BRIEF.md
# Edge/Center-Aligned PWM Timer

This block is a single pulse-width modulation channel running from the system clock. A 16-bit counter advances on a tick that is either every clock cycle or one cycle in 64. A period value sets the length of the PWM cycle, and a width value sets how long the output stays high. A mode bit selects one of two counting schemes. In edge mode the counter ramps up and wraps. In center mode it climbs to the period and falls back to zero, so a cycle lasts twice as long. The counting direction is set by the hardware alone.

Software reaches the block through a small word-wide register port with four locations: the counter, the period, the width and a control word. Period and width writes go to holding registers, and these are copied into the working registers only when a new PWM cycle starts. The run bit starts or freezes the counter. It does not touch the output, which keeps following the comparison between the counter and the width. A one-cycle match pulse marks each period compare, and in center mode also the return to zero.

Top module: `pwm_timer`

## Requirements
- R1: After reset, all four locations read back as zero, and `pwm_o` and `match_o` are low.
- R2: While the run bit (control bit 0) is 0, the counter holds its value. A write to location 0 loads the counter, and a read of location 0 returns that value. Reads return the addressed location one cycle after `addr` is presented.
- R3: The run bit does not gate the output. With the counter stopped, `pwm_o` is high exactly when the counter is below the working width.
- R4: When control bit 1 is 1, the counter advances only once every 64 clock cycles. When it is 0, the counter advances every cycle.
- R5: With control bit 2 at 0 (edge mode), a PWM cycle lasts period+1 ticks. Within each cycle the output is high for min(width, period+1) ticks.
- R6: With control bit 2 at 1 (center mode), the counter counts up to the period and then down to 0 under hardware control, so a cycle lasts 2×period ticks. The output is high for 2×width−1 ticks when the width is between 1 and the period, for every tick when the width is greater than the period, and for no tick when the width is 0.
- R7: A write to location 1 (period) or location 2 (width) reads back at once. It changes the output only after the start of the next PWM cycle.
- R8: `match_o` pulses for one cycle, on the cycle after a tick at which the counter equals the period. In center mode it also pulses after the tick at which the falling counter is 0. This gives one pulse per edge-mode cycle and two per center-mode cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed location |
| addr | input | 2 | Location: 0 counter, 1 period, 2 width, 3 control |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data for `addr` |
| pwm_o | output | 1 | Registered PWM output |
| match_o | output | 1 | One-cycle compare pulse |

## Verification
The main function is driven with a table of edge-mode and center-mode settings. The widths in the table are zero, inside the period, and greater than the period. Counting high cycles and match pulses over a whole number of cycles separates the cycle-length formulas of the two modes and shows where the output saturates. Center widths of 1 and of mid-range check the 2×width−1 count, which would come out wrong if the counter stayed at its turning points for an extra tick. Directed runs with the counter stopped show that the output follows the counter and not the run bit, and that a held width write leaves the output unchanged. A slow-tick run checks the 64-cycle spacing of ticks.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    LOC_COUNT  = 2'd0,
    LOC_PERIOD = 2'd1,
    LOC_WIDTH  = 2'd2,
    LOC_CTRL   = 2'd3
  } loc_e;

  // bit 2 center mode, bit 1 slow tick, bit 0 run
  typedef struct packed {
    logic center;
    logic slow;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = 3;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         load_i,
  input  logic [W-1:0] cnt_i,
  output ctrl_t        ctrl_o,
  output logic [W-1:0] per_sh_o,
  output logic [W-1:0] per_act_o,
  output logic [W-1:0] wid_act_o,
  output logic [W-1:0] rdata
);
  logic [W-1:0] per_sh_q, wid_sh_q, per_act_q, wid_act_q;
  ctrl_t        ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_sh_q <= '0;
      wid_sh_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      case (loc_e'(addr))
        LOC_PERIOD: per_sh_q <= wdata;
        LOC_WIDTH:  wid_sh_q <= wdata;
        LOC_CTRL:   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  // working copies move only at a cycle boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      per_act_q <= '0;
      wid_act_q <= '0;
    end else if (load_i) begin
      per_act_q <= per_sh_q;
      wid_act_q <= wid_sh_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (loc_e'(addr))
        LOC_COUNT:  rdata <= cnt_i;
        LOC_PERIOD: rdata <= per_sh_q;
        LOC_WIDTH:  rdata <= wid_sh_q;
        default:    rdata <= W'(ctrl_q);
      endcase
    end
  end

  assign ctrl_o    = ctrl_q;
  assign per_sh_o  = per_sh_q;
  assign per_act_o = per_act_q;
  assign wid_act_o = wid_act_q;
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         center_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic [W-1:0] per_act_i,
  input  logic [W-1:0] per_sh_i,
  input  logic [W-1:0] wid_act_i,
  output logic         load_o,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         pwm_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q;
  logic         down_q, pwm_q, match_q;
  logic         boundary, hit;

  always_comb begin
    if (center_i) begin
      boundary = (cnt_q == '0) && (down_q || (per_act_i == '0));
      hit      = (!down_q && (cnt_q == per_act_i)) || (down_q && (cnt_q == '0));
    end else begin
      boundary = (cnt_q >= per_act_i);
      hit      = (cnt_q == per_act_i);
    end
  end

  assign load_o = tick_i && boundary && !cnt_wr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (cnt_wr_i) begin
      cnt_q <= cnt_wdata_i;
    end else if (tick_i) begin
      if (!center_i) begin
        down_q <= 1'b0;
        cnt_q  <= boundary ? '0 : cnt_q + 1'b1;
      end else if (boundary) begin
        down_q <= 1'b0;
        cnt_q  <= (per_sh_i == '0) ? '0 : W'(1);
      end else if (!down_q && (cnt_q >= per_act_i)) begin
        down_q <= 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end else if (down_q) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      pwm_q   <= (cnt_q < wid_act_i);
      match_q <= tick_i && !cnt_wr_i && hit;
    end
  end

  assign cnt_o   = cnt_q;
  assign down_o  = down_q;
  assign pwm_o   = pwm_q;
  assign match_o = match_q;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_DIV = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             pwm_o,
  output logic             match_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] per_sh, per_act, wid_act, cnt;
  logic             pre_tick, tick, load, cnt_wr, down;
  logic             run_w, slow_w, center_w;

  assign run_w    = ctrl.run;
  assign slow_w   = ctrl.slow;
  assign center_w = ctrl.center;
  assign tick     = run_w && (slow_w ? pre_tick : 1'b1);
  assign cnt_wr   = wr_en && (loc_e'(addr) == LOC_COUNT);

  pwm_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_o(pre_tick)
  );

  pwm_regfile #(.W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .load_i(load), .cnt_i(cnt), .ctrl_o(ctrl), .per_sh_o(per_sh),
    .per_act_o(per_act), .wid_act_o(wid_act), .rdata(rdata)
  );

  pwm_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick_i(tick), .center_i(center_w),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(wdata), .per_act_i(per_act),
    .per_sh_i(per_sh), .wid_act_i(wid_act), .load_o(load), .cnt_o(cnt),
    .down_o(down), .pwm_o(pwm_o), .match_o(match_o)
  );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         center,
  input logic         run,
  input logic         slow,
  input logic         pre_tick,
  input logic         cnt_wr,
  input logic [W-1:0] cnt,
  input logic         down,
  input logic [W-1:0] per_act,
  input logic [W-1:0] wid_act,
  input logic         pwm_o,
  input logic         match_o
);
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));

  p_slow_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (slow && !pre_tick && !cnt_wr) |=> $stable(cnt));

  p_zero_width_r5: assert property (@(posedge clk) disable iff (rst)
    (wid_act == '0) |=> !pwm_o);

  p_down_step_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && center && down && (cnt != '0) && !cnt_wr) |=> (cnt == ($past(cnt) - W'(1))));

  p_match_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(tick));

  p_match_single_r8: assert property (@(posedge clk) disable iff (rst)
    (match_o && !center && (per_act != '0)) |=> !match_o);
endmodule

bind pwm_timer pwm_timer_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .center(center_w), .run(run_w),
  .slow(slow_w), .pre_tick(pre_tick), .cnt_wr(cnt_wr), .cnt(cnt),
  .down(down), .per_act(per_act), .wid_act(wid_act), .pwm_o(pwm_o),
  .match_o(match_o)
);

// File: tb/sim_pwm_timer.sv
`timescale 1ns/1ps
module sim_pwm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pwm_o, match_o;
  int          total = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  pwm_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_o(pwm_o), .match_o(match_o)
  );

  // center, period, width, cycle ticks, high ticks per cycle
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0, 4, 2, 5, 2},
    '{0, 7, 0, 8, 0},
    '{0, 5, 9, 6, 6},
    '{1, 4, 2, 8, 3},
    '{1, 6, 7, 12, 12},
    '{1, 3, 1, 6, 1}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    v = int'(rdata);
  endtask

  task automatic measure(input int n, output int hi, output int m);
    hi = 0; m = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hi += int'(pwm_o);
      m  += int'(match_o);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int v, hi, m;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pwm_o", int'(pwm_o), 0);
    check("R1 match_o", int'(match_o), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset readback", v, 0);
    end

    // table of edge and center settings
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, 16'(VEC[i][2]));
      wr(2'd1, 16'(VEC[i][1]));
      wr(2'd3, VEC[i][0] != 0 ? 16'd5 : 16'd1);
      repeat (200) @(negedge clk);
      measure(4 * VEC[i][3], hi, m);
      check(VEC[i][0] != 0 ? "R6 high ticks" : "R5 high ticks", hi, 4 * VEC[i][4]);
      check("R8 match count", m, VEC[i][0] != 0 ? 8 : 4);
    end

    // stopped counter: output follows counter, not run bit
    wr(2'd2, 16'd5);
    wr(2'd1, 16'd9);
    wr(2'd3, 16'd1);
    repeat (100) @(negedge clk);
    wr(2'd3, 16'd0);
    wr(2'd0, 16'd2);
    repeat (2) @(negedge clk);
    check("R3 stopped below width", int'(pwm_o), 1);
    measure(30, hi, m);
    check("R3 output held while stopped", hi, 30);
    check("R2 no match while stopped", m, 0);
    wr(2'd0, 16'd7);
    repeat (2) @(negedge clk);
    check("R3 stopped above width", int'(pwm_o), 0);
    wr(2'd2, 16'd9);
    rd(2'd2, v);
    check("R7 width readback", v, 9);
    measure(20, hi, m);
    check("R7 held width not yet active", hi, 0);
    rd(2'd0, v);
    check("R2 counter held", v, 7);
    wr(2'd0, 16'h1234);
    repeat (30) @(negedge clk);
    rd(2'd0, v);
    check("R2 counter load readback", v, 16'h1234);
    wr(2'd3, 16'd1);
    repeat (100) @(negedge clk);
    measure(40, hi, m);
    check("R7 new width after boundary", hi, 36);

    // slow tick
    wr(2'd2, 16'd1);
    wr(2'd1, 16'd3);
    wr(2'd3, 16'd3);
    repeat (800) @(negedge clk);
    measure(512, hi, m);
    check("R4 slow high cycles", hi, 128);
    check("R4 slow match count", m, 2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule